// File: doc/BRIEF.md
# Dual-Law Serial Clock Generator

This block derives a serial-interface clock from the module clock. It also produces two single-cycle strobes that a shift register can use to launch and capture data. A configuration word selects between two division laws. The linear law gives an even divide of 2·(N+1). The power-of-two law gives a divide of 2^M. The mode bit picks which of the two fields applies.

The clock runs only while `active` is high. When `active` is low, the clock sits at the idle level given by `cpol`. A run always begins with the clock at idle level and always ends with the clock back at idle level, so it never leaves a half period behind.

The divisor is captured when a run starts. Writing a new configuration word during a run has no effect until the clock has gone idle and is started again.

Top module: `spiclk_divider`

## Requirements
- R1: After reset, `sclk` equals `cpol`, and both `lead_stb` and `trail_stb` are low.
- R2: When `cfg[12]` = 1 (linear law), the serial clock period is 2·(N+1) module-clock cycles, where N = `cfg[7:0]`.
- R3: When `cfg[12]` = 0 (power-of-two law), the serial clock period is 2^M module-clock cycles, where M = `cfg[11:8]`.
- R4: The fastest rate is half the module clock. This applies to N = 0 in linear mode, and to both M = 0 and M = 1 in power-of-two mode.
- R5: While no run is in progress, `sclk` equals `cpol`. After `active` is sampled high, `sclk` stays at idle level for one half period before its first transition.
- R6: `lead_stb` is high for exactly one cycle, in the cycle where `sclk` first shows the non-idle level. `trail_stb` is high for exactly one cycle, in the cycle where `sclk` returns to idle. The two strobes are never high together.
- R7: When `active` falls, the current period is completed and the clock then stops at idle level. Every leading edge of a run is matched by a trailing edge. A run that ends before its first leading edge produces no edges at all.
- R8: The divisor is taken from `cfg` only when a run starts. Changes to `cfg` during a run leave the period unchanged until the next run.
- R9: With `cpol` = 1, the idle level is high and the leading edge is a falling transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 13 | Division word: [7:0] N, [11:8] M, [12] mode (1 = linear law) |
| active | input | 1 | Transfer request; the clock runs while this is high |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on a transition away from idle |
| trail_stb | output | 1 | One-cycle strobe on a transition back to idle |

## Verification
The edge-direction assertions assume that `cpol` does not change while a run is in progress. The stimulus therefore changes `cpol` only during idle gaps, after the clock has stopped. The assertions place no limits on `cfg` or `active`. The stimulus takes advantage of this: it rewrites `cfg` in the middle of a run, and it drops `active` both before and after the first leading edge, so that the capture-at-start and stop-at-boundary rules are exercised.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

  typedef enum logic {
    DIV_POW2 = 1'b0,
    DIV_LIN  = 1'b1
  } div_law_e;

endpackage

// File: rtl/spiclk_decode.sv
module spiclk_decode #(
  parameter int LIN_W  = 8,
  parameter int POW_W  = 4,
  parameter int TERM_W = 14,
  localparam int CFG_W = LIN_W + POW_W + 1
) (
  input  logic [CFG_W-1:0]  cfg,
  output logic [TERM_W-1:0] term
);
  import spiclk_pkg::*;

  localparam int EXT_W = TERM_W + 1;

  // Linear law: half period is N+1 cycles, so the terminal count is N.
  function automatic logic [TERM_W-1:0] lin_term(input logic [LIN_W-1:0] n);
    lin_term = TERM_W'(n);
  endfunction

  // Power-of-two law: half period 2^(M-1); M = 0 is clamped to the M = 1 rate.
  function automatic logic [TERM_W-1:0] pow_term(input logic [POW_W-1:0] m);
    logic [EXT_W-1:0] half;
    if (m == '0) half = EXT_W'(1);
    else         half = EXT_W'(1) << (m - 1'b1);
    pow_term = TERM_W'(half - EXT_W'(1));
  endfunction

  div_law_e         law;
  logic [LIN_W-1:0] n_fld;
  logic [POW_W-1:0] m_fld;

  assign n_fld = cfg[LIN_W-1:0];
  assign m_fld = cfg[LIN_W+POW_W-1:LIN_W];
  assign law   = div_law_e'(cfg[CFG_W-1]);

  always_comb begin
    case (law)
      DIV_LIN: term = lin_term(n_fld);
      default: term = pow_term(m_fld);
    endcase
  end

endmodule

// File: rtl/spiclk_half_timer.sv
module spiclk_half_timer #(
  parameter int TERM_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [TERM_W-1:0] term_in,
  output logic [TERM_W-1:0] term_q,
  output logic [TERM_W-1:0] cnt,
  output logic              tick
);

  assign tick = run && (cnt == term_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      cnt    <= '0;
    end else if (load) begin
      term_q <= term_in;
      cnt    <= '0;
    end else if (run) begin
      if (tick) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spiclk_phase_ctrl.sv
module spiclk_phase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic running,
  output logic phase,
  output logic load,
  output logic lead_stb,
  output logic trail_stb
);

  logic go_lead;
  logic go_trail;

  assign load     = !running && active;
  assign go_lead  = tick && !phase && active;
  assign go_trail = tick && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= 1'b0;
    end else if (load) begin
      running <= 1'b1;
      phase   <= 1'b0;
    end else if (tick) begin
      if (!phase) begin
        if (active) phase   <= 1'b1;
        else        running <= 1'b0;
      end else begin
        phase <= 1'b0;
        if (!active) running <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= go_lead;
      trail_stb <= go_trail;
    end
  end

endmodule

// File: rtl/spiclk_divider.sv
module spiclk_divider #(
  parameter int LIN_W  = 8,
  parameter int POW_W  = 4,
  localparam int CFG_W = LIN_W + POW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             active,
  input  logic             cpol,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);

  localparam int POW_SPAN = (1 << POW_W) - 2;
  localparam int TERM_W   = (LIN_W > POW_SPAN) ? LIN_W : POW_SPAN;

  logic [TERM_W-1:0] term_new;
  logic [TERM_W-1:0] term_q;
  logic [TERM_W-1:0] cnt;
  logic              half_tick;
  logic              running;
  logic              phase;
  logic              load;

  spiclk_decode #(
    .LIN_W (LIN_W),
    .POW_W (POW_W),
    .TERM_W(TERM_W)
  ) u_decode (
    .cfg (cfg),
    .term(term_new)
  );

  spiclk_half_timer #(
    .TERM_W(TERM_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .run    (running),
    .term_in(term_new),
    .term_q (term_q),
    .cnt    (cnt),
    .tick   (half_tick)
  );

  spiclk_phase_ctrl u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .tick     (half_tick),
    .running  (running),
    .phase    (phase),
    .load     (load),
    .lead_stb (lead_stb),
    .trail_stb(trail_stb)
  );

  assign sclk = cpol ^ phase;

endmodule

// File: rtl/spiclk_divider_chk.sv
module spiclk_divider_chk #(
  parameter int TERM_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpol,
  input logic              sclk,
  input logic              lead_stb,
  input logic              trail_stb,
  input logic              running,
  input logic [TERM_W-1:0] cnt,
  input logic [TERM_W-1:0] term_q
);

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (sclk == cpol));

  p_lead_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb);

  p_trail_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |=> !trail_stb);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  p_lead_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != cpol) && ($past(sclk) == cpol));

  p_trail_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk == cpol) && ($past(sclk) != cpol));

  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> (sclk == cpol) && !lead_stb);

  p_term_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(term_q));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= term_q);

endmodule

bind spiclk_divider spiclk_divider_chk #(.TERM_W(TERM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpol     (cpol),
  .sclk     (sclk),
  .lead_stb (lead_stb),
  .trail_stb(trail_stb),
  .running  (running),
  .cnt      (cnt),
  .term_q   (term_q)
);

// File: tb/sim_spiclk_divider.sv
`timescale 1ns/1ps
module sim_spiclk_divider;

  localparam int CW    = 13;
  localparam int LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg = '0;
  logic          active = 1'b0;
  logic          cpol = 1'b0;
  logic          sclk, lead_stb, trail_stb;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int n_lead = 0;
  int n_trail = 0;
  int lead_t[$];

  // reference model state
  int  m_run = 0, m_cnt = 0, m_ph = 0, m_term = 0;
  bit  e_lead, e_trail;

  always #2.5 clk = ~clk;

  spiclk_divider u0 (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .active(active), .cpol(cpol),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  function automatic logic [CW-1:0] mk_lin(input int n);
    return {1'b1, 4'd0, 8'(n)};
  endfunction

  function automatic logic [CW-1:0] mk_pow(input int m);
    return {1'b0, 4'(m), 8'd0};
  endfunction

  // half period minus one, derived from the full period of each law
  function automatic int ref_term(input logic [CW-1:0] c);
    int period;
    if (c[12]) period = 2 * (int'(c[7:0]) + 1);
    else if (c[11:8] == 0) period = 2;
    else period = 1 << int'(c[11:8]);
    return period / 2 - 1;
  endfunction

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    e_lead = 0;
    e_trail = 0;
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_ph = 0; m_term = 0;
    end else if (m_run == 0) begin
      if (active) begin
        m_run = 1; m_cnt = 0; m_ph = 0; m_term = ref_term(cfg);
      end
    end else if (m_cnt == m_term) begin
      m_cnt = 0;
      if (m_ph == 0) begin
        if (active) begin m_ph = 1; e_lead = 1; end
        else m_run = 0;
      end else begin
        m_ph = 0; e_trail = 1;
        if (!active) m_run = 0;
      end
    end else begin
      m_cnt++;
    end
    if (rst_n) begin
      chk(sclk == (cpol ^ m_ph[0]), "R5/R9 sclk level", sclk, cpol ^ m_ph[0]);
      chk(lead_stb == e_lead, "R6 lead_stb", lead_stb, e_lead);
      chk(trail_stb == e_trail, "R6 trail_stb", trail_stb, e_trail);
    end
    if (lead_stb) begin n_lead++; lead_t.push_back(cyc); end
    if (trail_stb) n_trail++;
    if (cyc > LIMIT) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
      finish_up();
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Run a burst and return the spacing of its last two leading edges.
  task automatic burst(input logic [CW-1:0] c, input bit pol, input int len,
                       output int period);
    @(negedge clk);
    cfg = c; cpol = pol;
    lead_t.delete(); n_lead = 0; n_trail = 0;
    active = 1'b1;
    wait_cyc(len);
    active = 1'b0;
    wait_cyc(2 * (ref_term(c) + 1) + 4);
    if (lead_t.size() >= 2) period = lead_t[$] - lead_t[$-1];
    else period = -1;
  endtask

  initial begin
    int p;
    wait_cyc(3);
    // R1: reset state
    chk(sclk == cpol && !lead_stb && !trail_stb, "R1 reset idle", sclk, cpol);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(sclk == cpol, "R1 idle after reset", sclk, cpol);

    burst(mk_lin(3), 1'b0, 60, p);  chk(p == 8, "R2 linear N=3", p, 8);
    chk(n_lead == n_trail, "R7 edges matched", n_lead, n_trail);
    burst(mk_lin(10), 1'b0, 120, p); chk(p == 22, "R2 linear N=10", p, 22);
    burst(mk_lin(0), 1'b0, 20, p);  chk(p == 2, "R4 linear N=0", p, 2);
    burst(mk_pow(0), 1'b0, 20, p);  chk(p == 2, "R4 pow M=0", p, 2);
    burst(mk_pow(1), 1'b0, 20, p);  chk(p == 2, "R4 pow M=1", p, 2);
    burst(mk_pow(3), 1'b0, 60, p);  chk(p == 8, "R3 pow M=3", p, 8);
    burst(mk_pow(5), 1'b0, 200, p); chk(p == 32, "R3 pow M=5", p, 32);
    burst(mk_pow(7), 1'b1, 600, p); chk(p == 128, "R3/R9 pow M=7 cpol=1", p, 128);
    chk(sclk == 1'b1, "R9 idle high", sclk, 1);
    chk(n_lead == n_trail, "R7 edges matched cpol=1", n_lead, n_trail);
    // mode bit with both fields loaded: linear N=1 (period 4) vs pow M=4 (16)
    burst({1'b1, 4'd4, 8'd1}, 1'b0, 40, p);  chk(p == 4, "R2 mode bit linear", p, 4);
    burst({1'b0, 4'd4, 8'd1}, 1'b0, 100, p); chk(p == 16, "R3 mode bit pow", p, 16);

    // R8: divisor change during a run is ignored until the next run
    @(negedge clk);
    cfg = mk_lin(1); cpol = 1'b0;
    lead_t.delete(); n_lead = 0; n_trail = 0;
    active = 1'b1;
    wait_cyc(10);
    cfg = mk_lin(5);
    wait_cyc(30);
    p = lead_t[$] - lead_t[$-1];
    chk(p == 4, "R8 change ignored mid-run", p, 4);
    active = 1'b0;
    wait_cyc(10);
    burst(mk_lin(5), 1'b0, 80, p); chk(p == 12, "R8 new divisor next run", p, 12);

    // R7: run ends before the first leading edge
    @(negedge clk);
    cfg = mk_pow(4); n_lead = 0; n_trail = 0;
    active = 1'b1;
    wait_cyc(3);
    active = 1'b0;
    wait_cyc(20);
    chk(n_lead == 0 && n_trail == 0, "R7 short run no edges", n_lead, 0);
    chk(sclk == cpol, "R7 idle after short run", sclk, cpol);

    // R5: first edge one half period after start
    @(negedge clk);
    cfg = mk_lin(4); lead_t.delete();
    active = 1'b1;
    p = cyc;
    wait_cyc(30);
    active = 1'b0;
    wait_cyc(20);
    chk(lead_t[0] - p == 6, "R5 first edge delay", lead_t[0] - p, 6);

    finish_up();
  end

endmodule